// File: doc/BRIEF.md
# Stopwatch Timebase with Button Control

This block is the timing core of a push-button stopwatch. A free-running divider turns the system clock into a one-cycle millisecond tick. An elapsed-time counter adds one on each tick, but only while a run flag is set. Three button events work the flag and the counter: start, stop and zero. The other two buttons of the group are ignored. The low bits of the elapsed count drive a row of LEDs.

Button edges arrive already debounced and reduced to one-cycle rise pulses on a 5-bit bus. The divide ratio is a parameter. Its default of 100000 gives a 1 ms tick from a 100 MHz clock. The counter width and the LED width are parameters too. Reset is synchronous and active high.

Top module: `stopwatch_timebase`

## Requirements
- R1: The divider steps through 0 to DIV_LIMIT-1 and then back to 0. `msPulse` is high for exactly one cycle in every DIV_LIMIT cycles. The first pulse comes in the DIV_LIMIT-th cycle after reset is released.
- R2: While reset is applied, and in the first cycle after it, `running` is 0 and `elapsedMs` is 0.
- R3: A pulse on `btnRise[4]` (start) sets `running` from the next cycle onward.
- R4: A pulse on `btnRise[0]` (stop) clears `running` from the next cycle onward. If start and stop pulse in the same cycle, stop wins and `running` is 0 afterwards.
- R5: `elapsedMs` rises by one after each clock edge where `msPulse` and the pre-edge `running` are both high. It holds its value after every other edge, except for the case in R6.
- R6: A pulse on `btnRise[1]` (zero) makes `elapsedMs` 0 after the edge. This overrides an increment on the same edge and leaves `running` unchanged.
- R7: Pulses on `btnRise[2]` and `btnRise[3]` have no effect on `running`, `elapsedMs` or `msPulse`.
- R8: `led` always equals the low LED_W bits of `elapsedMs`. `elapsedMs` wraps from all-ones to 0 with no other indication.
- R9: The divider runs regardless of `running` and the buttons. Ticks keep coming while stopped, and a start does not restart the divider phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btnRise | input | 5 | One-cycle rise pulses: bit 0 stop, bit 1 zero, bit 2 and bit 3 unused, bit 4 start |
| msPulse | output | 1 | One-cycle millisecond tick |
| running | output | 1 | Run flag |
| elapsedMs | output | COUNT_W | Elapsed milliseconds |
| led | output | LED_W | Low bits of the elapsed count |

## Verification
The hardest cases to reach from the ports are the ones that hinge on the divider phase. One is a zero pulse that lands on the same edge as a counted tick. The other is a start pulse that lands just before a tick, which must not shift the following ticks. The stimulus tracks the divider phase from the moment reset is released. It steps idle cycles until the next cycle is a tick cycle, and only then issues the zero or start pulse. Wrap-around is reached by building the bench with a 6-bit counter and a divide ratio of 4, so that 64 ticks take a few hundred cycles.

// File: rtl/sw_pkg.sv
package sw_pkg;

  localparam int unsigned BTN_W     = 5;
  localparam int unsigned BTN_STOP  = 0;
  localparam int unsigned BTN_ZERO  = 1;
  localparam int unsigned BTN_DOWN  = 2;
  localparam int unsigned BTN_LEFT  = 3;
  localparam int unsigned BTN_START = 4;

  typedef struct packed {
    logic stepCount;
    logic clearCount;
  } swStrobes_t;

endpackage

// File: rtl/sw_tick_divider.sv
module sw_tick_divider #(
  parameter int unsigned DIV_LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int unsigned CNT_W = (DIV_LIMIT > 1) ? $clog2(DIV_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_LIMIT - 1);

  generate
    if (DIV_LIMIT <= 1) begin : g_every_cycle
      logic unusedInputs;
      assign unusedInputs = clk ^ rst;
      assign tick = 1'b1;
    end else begin : g_count
      logic [CNT_W-1:0] divCnt;
      logic atLast;

      assign atLast = (divCnt == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          divCnt <= '0;
        end else if (atLast) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end

      assign tick = atLast;
    end
  endgenerate

endmodule

// File: rtl/sw_control.sv
module sw_control
  import sw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic             zeroEv,
  input  logic             msTick,
  output logic             running,
  output swStrobes_t       strobes
);

  logic runNext;

  always_comb begin
    runNext = running;
    if (stopEv) begin
      runNext = 1'b0;
    end else if (startEv) begin
      runNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else begin
      running <= runNext;
    end
  end

  always_comb begin
    strobes.stepCount  = msTick & running;
    strobes.clearCount = zeroEv;
  end

endmodule

// File: rtl/sw_elapsed_datapath.sv
module sw_elapsed_datapath
  import sw_pkg::*;
#(
  parameter int unsigned COUNT_W = 32,
  parameter int unsigned LED_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  swStrobes_t         strobes,
  output logic [COUNT_W-1:0] elapsed,
  output logic [LED_W-1:0]   ledBits
);

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
    end else if (strobes.clearCount) begin
      elapsed <= '0;
    end else if (strobes.stepCount) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign ledBits = elapsed[LED_W-1:0];

endmodule

// File: rtl/stopwatch_timebase.sv
module stopwatch_timebase
  import sw_pkg::*;
#(
  parameter int unsigned DIV_LIMIT = 100000,
  parameter int unsigned COUNT_W   = 32,
  parameter int unsigned LED_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BTN_W-1:0]   btnRise,
  output logic               msPulse,
  output logic               running,
  output logic [COUNT_W-1:0] elapsedMs,
  output logic [LED_W-1:0]   led
);

  swStrobes_t strobes;
  logic       unusedBtns;

  assign unusedBtns = btnRise[BTN_DOWN] ^ btnRise[BTN_LEFT];

  sw_tick_divider #(.DIV_LIMIT(DIV_LIMIT)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (msPulse)
  );

  sw_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .startEv (btnRise[BTN_START]),
    .stopEv  (btnRise[BTN_STOP]),
    .zeroEv  (btnRise[BTN_ZERO]),
    .msTick  (msPulse),
    .running (running),
    .strobes (strobes)
  );

  sw_elapsed_datapath #(.COUNT_W(COUNT_W), .LED_W(LED_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .elapsed (elapsedMs),
    .ledBits (led)
  );

endmodule

// File: rtl/sw_checker.sv
module sw_checker
  import sw_pkg::*;
#(
  parameter int unsigned DIV_LIMIT = 100000,
  parameter int unsigned COUNT_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [BTN_W-1:0]   btnRise,
  input logic               msPulse,
  input logic               running,
  input logic [COUNT_W-1:0] elapsedMs
);

  logic [31:0] sinceTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceTick <= '0;
    end else if (msPulse) begin
      sinceTick <= '0;
    end else begin
      sinceTick <= sinceTick + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    msPulse |-> sinceTick == 32'(DIV_LIMIT - 1)); // R1
  AST_TICK_DUE: assert property (@(posedge clk) disable iff (rst)
    (sinceTick == 32'(DIV_LIMIT - 1)) |-> msPulse); // R1
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!running && elapsedMs == '0)); // R2
  AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
    (btnRise[BTN_START] && !btnRise[BTN_STOP]) |=> running); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
    btnRise[BTN_STOP] |=> !running); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (msPulse && running && !btnRise[BTN_ZERO]) |=>
      elapsedMs == COUNT_W'($past(elapsedMs) + 1'b1)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(msPulse && running) && !btnRise[BTN_ZERO]) |=> $stable(elapsedMs)); // R5
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    btnRise[BTN_ZERO] |=> elapsedMs == '0); // R6
  AST_ZERO_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (btnRise[BTN_ZERO] && !btnRise[BTN_STOP] && !btnRise[BTN_START]) |=> $stable(running)); // R6
  AST_IDLE_BUTTONS: assert property (@(posedge clk) disable iff (rst)
    (!btnRise[BTN_STOP] && !btnRise[BTN_START]) |=> $stable(running)); // R7

endmodule

bind stopwatch_timebase sw_checker #(.DIV_LIMIT(DIV_LIMIT), .COUNT_W(COUNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .btnRise   (btnRise),
  .msPulse   (msPulse),
  .running   (running),
  .elapsedMs (elapsedMs)
);

// File: tb/stopwatch_timebase_bench.sv
module stopwatch_timebase_bench;
  import sw_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned T_LIMIT = 4;
  localparam int unsigned T_CW    = 6;
  localparam int unsigned T_LW    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BTN_W-1:0] btnRise = '0;
  logic msPulse, running;
  logic [T_CW-1:0] elapsedMs;
  logic [T_LW-1:0] led;

  typedef struct {
    logic pulse;
    logic run;
    logic [T_CW-1:0] elap;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int mDiv = 0;
  logic mRun = 1'b0;
  logic [T_CW-1:0] mElap = '0;
  bit finished = 1'b0;

  stopwatch_timebase #(.DIV_LIMIT(T_LIMIT), .COUNT_W(T_CW), .LED_W(T_LW)) u_stopwatch_timebase (
    .clk(clk), .rst(rst), .btnRise(btnRise), .msPulse(msPulse),
    .running(running), .elapsedMs(elapsedMs), .led(led)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [BTN_W-1:0] b, input string tag);
    expItem_t it;
    @(negedge clk);
    btnRise = b;
    it.pulse = (mDiv == T_LIMIT - 1);
    it.run   = mRun;
    it.elap  = mElap;
    it.tag   = tag;
    expQ.push_back(it);
    if (b[BTN_ZERO]) mElap = '0;
    else if (it.pulse && mRun) mElap = mElap + 1'b1;
    if (b[BTN_STOP]) mRun = 1'b0;
    else if (b[BTN_START]) mRun = 1'b1;
    mDiv = it.pulse ? 0 : mDiv + 1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, tag);
  endtask

  task automatic toTickCycle(input string tag);
    while (mDiv != T_LIMIT - 1) step('0, tag);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops the expected item of the current cycle and compares.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checkVal(it.tag, "msPulse", int'(msPulse), int'(it.pulse));
        checkVal(it.tag, "running", int'(running), int'(it.run));
        checkVal(it.tag, "elapsedMs", int'(elapsedMs), int'(it.elap));
        checkVal({it.tag, " R8"}, "led", int'(led), int'(it.elap[T_LW-1:0]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    btnRise = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R2: state held in reset
    checkVal("R2 in reset", "running", int'(running), 0);
    checkVal("R2 in reset", "elapsedMs", int'(elapsedMs), 0);
    rst = 1'b0;
    // R1 R2 R9: ticks keep coming while stopped, count stays 0
    idle(3 * T_LIMIT, "R1 R9 stopped ticks");
    // R3: start
    step(5'b10000, "R3 start");
    idle(5 * T_LIMIT, "R5 counting");
    // R7: unused buttons while running
    step(5'b00100, "R7 down ignored");
    step(5'b01000, "R7 left ignored");
    step(5'b01100, "R7 both ignored");
    idle(2 * T_LIMIT, "R7 after unused");
    // R4: stop, then hold
    step(5'b00001, "R4 stop");
    idle(3 * T_LIMIT, "R5 hold while stopped");
    // R4: start and stop together, stop wins
    step(5'b10001, "R4 stop wins");
    idle(2 * T_LIMIT, "R4 after tie");
    // R9: start just before a tick, phase must not move
    toTickCycle("R9 align");
    step(5'b10000, "R9 start on tick cycle");
    idle(3 * T_LIMIT, "R9 phase kept");
    // R6: zero on a counted tick edge, running kept
    toTickCycle("R6 align");
    step(5'b00010, "R6 zero on tick");
    idle(2 * T_LIMIT, "R6 after zero");
    // R6 with start and zero while stopped
    step(5'b00001, "R4 stop again");
    step(5'b00010, "R6 zero while stopped");
    step(5'b10010, "R6 zero with start");
    // R8: run to wrap-around
    idle((1 << T_CW) * T_LIMIT + 3 * T_LIMIT, "R8 wrap");
    // R3: repeated start while running is harmless
    step(5'b10000, "R3 restart");
    idle(T_LIMIT, "R3 after restart");
    step('0, "drain");
    @(negedge clk);
    #(CLK_PERIOD/2);
    finished = 1'b1;
    finishRun();
  end

endmodule